// File: doc/BRIEF.md
# Watchdog Reboot Status and Recovery Register

This block keeps a 16-bit status word for a platform watchdog path. It records three events: a second timeout of the external watchdog, a boot failure (the processor never fetched its first instruction before that timeout), and a chassis intrusion. Each status bit stays set until software writes a 1 to it or the matching reset domain clears it. The watchdog counter is outside the block. The block only reacts to the timeout pulse that counter produces.

The same event that sets the timeout status also starts a fixed-length platform reset request. It also chooses the processor frequency multiplier to use on the next boot. If the boot-failure bit is set, the multiplier is forced to the all-ones safe value. Otherwise the programmed default passes through. The intrusion bit sits in the RTC well, so it is cleared only by the RTC-well reset and keeps recording while the resume well is held in reset.

Top module: `wdr_status_top`

## Requirements
- R1: After both resets, a read at offset 06h returns 0000h, `plat_rst_o` is low and `mult_sel_o` equals `mult_default_i`.
- R2: Bit 1 (timeout status) reads 1 one cycle after a rising edge on `wd_to_i`. Holding `wd_to_i` high does not set the bit again after it has been cleared.
- R3: Bit 1 clears only on a write at offset 06h with data bit 1 = 1, or on the resume-well reset. A write of 0, or a write at any other offset, leaves it unchanged.
- R4: Bit 2 (boot status) sets in the same cycle that bit 1 goes from 0 to 1, but only when `cpu_fetched_i` is low at that time.
- R5: Bit 2 clears only on a write at offset 06h with data bit 2 = 1, or on the resume-well reset.
- R6: When a set event and a write-1 clear land on the same bit in the same cycle, the bit stays 1.
- R7: `plat_rst_o` goes high in the same cycle that bit 1 goes from 0 to 1, and stays high for exactly RST_CYC cycles (default 8).
- R8: `mult_sel_o` is 4'b1111 while bit 2 is set and either bit 1 is set or `plat_rst_o` is high. At all other times it equals `mult_default_i`.
- R9: Bit 0 (intrusion) sets one cycle after a rising edge on `intrude_i`, even while the resume-well reset is asserted. The resume-well reset does not clear it. It clears only on a write of 1 to bit 0 at offset 06h, or on the RTC-well reset.
- R10: Bits 15 to 3 always read 0, and writing 1 to them has no effect. A read at any offset other than 06h returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rsm_rst_n | input | 1 | Resume-well reset, synchronous, active low |
| rtc_rst_n | input | 1 | RTC-well reset, synchronous, active low |
| wd_to_i | input | 1 | Second-timeout pulse from the external watchdog |
| cpu_fetched_i | input | 1 | High once the processor has fetched its first instruction |
| intrude_i | input | 1 | Chassis intrusion input |
| reg_addr_i | input | 8 | Register offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data (1 = clear bit) |
| reg_rdata_o | output | 16 | Read data for the addressed offset |
| mult_default_i | input | 4 | Programmed default multiplier |
| plat_rst_o | output | 1 | Platform reset request pulse |
| mult_sel_o | output | 4 | Multiplier for the next boot |

## Verification
All stimulus is driven on the falling edge. A status bit, whether set by an edge or cleared by a write, is therefore visible on the read port at the next falling edge, one rising edge later. The reset pulse and the forced multiplier appear at that same falling edge. The read port is combinational, so each task reads back immediately after the rising edge that should have changed the state. The pulse length is measured by counting consecutive falling edges on which `plat_rst_o` is high. Checks for "no effect" read back the full word right after the ignored write, before any other stimulus.

// File: rtl/wdr_pkg.sv
// Package: shared field positions and the status type for the
// watchdog reboot status register. Assumes a 3-bit live field.
package wdr_pkg;
    localparam int BIT_INTR = 0;
    localparam int BIT_TO   = 1;
    localparam int BIT_BOOT = 2;
    localparam int LIVE_W   = 3;

    typedef struct packed {
        logic boot;
        logic to;
        logic intr;
    } wdr_stat_t;
endpackage

// File: rtl/wdr_edge_det.sv
// Module: rising-edge detector over W independent lines.
// Assumes inputs are already synchronous to clk. Active-low sync reset.
module wdr_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Remember the previous sample of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= d_i;
    end

    // One-cycle pulse per 0->1 transition, per line.
    for (genvar i = 0; i < W; i++) begin : g_rise
        assign rise_o[i] = d_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/wdr_status_bits.sv
// Module: the three live status bits, with write-one-to-clear and set priority.
// Timeout and boot bits live in the resume well; the intrusion bit lives
// in the RTC well. Assumes set events are single-cycle pulses.
module wdr_status_bits
    import wdr_pkg::*;
(
    input  logic              clk,
    input  logic              rsm_rst_n,
    input  logic              rtc_rst_n,
    input  logic              to_rise_i,
    input  logic              intr_rise_i,
    input  logic              cpu_fetched_i,
    input  logic [LIVE_W-1:0] clr_mask_i,
    output wdr_stat_t         stat_o,
    output logic              to_first_o
);
    logic to_q, boot_q, intr_q;

    // A 0->1 transition of the timeout status this cycle.
    assign to_first_o = to_rise_i & ~to_q;

    // Timeout status: a set event beats a clear.
    always_ff @(posedge clk) begin
        if (!rsm_rst_n)                to_q <= 1'b0;
        else if (to_rise_i)            to_q <= 1'b1;
        else if (clr_mask_i[BIT_TO])   to_q <= 1'b0;
    end

    // Boot status: set only when timeout rises before the first fetch.
    always_ff @(posedge clk) begin
        if (!rsm_rst_n)                       boot_q <= 1'b0;
        else if (to_first_o && !cpu_fetched_i) boot_q <= 1'b1;
        else if (clr_mask_i[BIT_BOOT])        boot_q <= 1'b0;
    end

    // Intrusion flag: RTC-well reset only.
    always_ff @(posedge clk) begin
        if (!rtc_rst_n)                intr_q <= 1'b0;
        else if (intr_rise_i)          intr_q <= 1'b1;
        else if (clr_mask_i[BIT_INTR]) intr_q <= 1'b0;
    end

    assign stat_o = '{boot: boot_q, to: to_q, intr: intr_q};

    AST_TO_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        $fell(to_q) |-> $past(clr_mask_i[BIT_TO]));                       // R3
    AST_BOOT_RISE_COND: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        $rose(boot_q) |-> ($rose(to_q) && !$past(cpu_fetched_i)));        // R4
    AST_BOOT_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        $fell(boot_q) |-> $past(clr_mask_i[BIT_BOOT]));                   // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        to_rise_i |=> to_q);                                              // R6
    AST_INTR_KEEP: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        (intr_q && !clr_mask_i[BIT_INTR]) |=> intr_q);                    // R9
endmodule

// File: rtl/wdr_reboot_ctl.sv
// Module: platform reset pulse generator and next-boot multiplier select.
// Assumes trig_i is a single-cycle pulse at the timeout status rise.
module wdr_reboot_ctl #(
    parameter int RST_CYC = 8,
    parameter int MULT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              to_i,
    input  logic              boot_i,
    input  logic [MULT_W-1:0] dflt_i,
    output logic              plat_rst_o,
    output logic [MULT_W-1:0] mult_o
);
    localparam int CNT_W = $clog2(RST_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYC);
    localparam logic [MULT_W-1:0] SAFE_MULT = '1;

    logic [CNT_W-1:0] cnt_q;

    // Load on trigger, then count the pulse down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (trig_i)        cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign plat_rst_o = (cnt_q != '0);

    // Safe multiplier while a failed boot is pending or rebooting.
    always_comb begin
        if (boot_i && (to_i || plat_rst_o)) mult_o = SAFE_MULT;
        else                                mult_o = dflt_i;
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> plat_rst_o);                                   // R7
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(plat_rst_o) |-> $past(trig_i));                     // R7
    AST_SAFE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (plat_rst_o && boot_i) |-> (mult_o == SAFE_MULT));        // R8
endmodule

// File: rtl/wdr_status_top.sv
// Module: watchdog reboot status register top. Decodes the register port,
// edge-detects the event inputs and drives the reboot outputs.
// Assumes all inputs are synchronous to clk; reads are combinational.
module wdr_status_top
    import wdr_pkg::*;
#(
    parameter int               ADDR_W  = 8,
    parameter int               DATA_W  = 16,
    parameter int               MULT_W  = 4,
    parameter int               RST_CYC = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h06
) (
    input  logic              clk,
    input  logic              rsm_rst_n,
    input  logic              rtc_rst_n,
    input  logic              wd_to_i,
    input  logic              cpu_fetched_i,
    input  logic              intrude_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [MULT_W-1:0] mult_default_i,
    output logic              plat_rst_o,
    output logic [MULT_W-1:0] mult_sel_o
);
    localparam int RSVD_W = DATA_W - LIVE_W;

    logic              hit;
    logic [LIVE_W-1:0] clr_mask;
    logic              to_rise, intr_rise, to_first;
    wdr_stat_t         stat;

    // Address match for the single register.
    assign hit      = (reg_addr_i == REG_OFS);
    assign clr_mask = (reg_wr_i && hit) ? reg_wdata_i[LIVE_W-1:0] : '0;

    wdr_edge_det #(.W(1)) u_to_edge (
        .clk(clk), .rst_n(rsm_rst_n), .d_i(wd_to_i), .rise_o(to_rise));

    wdr_edge_det #(.W(1)) u_intr_edge (
        .clk(clk), .rst_n(rtc_rst_n), .d_i(intrude_i), .rise_o(intr_rise));

    wdr_status_bits u_bits (
        .clk(clk), .rsm_rst_n(rsm_rst_n), .rtc_rst_n(rtc_rst_n),
        .to_rise_i(to_rise), .intr_rise_i(intr_rise),
        .cpu_fetched_i(cpu_fetched_i), .clr_mask_i(clr_mask),
        .stat_o(stat), .to_first_o(to_first));

    wdr_reboot_ctl #(.RST_CYC(RST_CYC), .MULT_W(MULT_W)) u_reboot (
        .clk(clk), .rst_n(rsm_rst_n), .trig_i(to_first),
        .to_i(stat.to), .boot_i(stat.boot), .dflt_i(mult_default_i),
        .plat_rst_o(plat_rst_o), .mult_o(mult_sel_o));

    // Read mux: live bits at the register offset, zero elsewhere.
    assign reg_rdata_o = hit ? {{RSVD_W{1'b0}}, stat} : '0;

    AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (reg_wr_i && hit && reg_wdata_i[LIVE_W-1:0] == '0 && !wd_to_i)
            |=> $stable(stat.to));                                // R10
endmodule

// File: tb/wdr_status_top_tb.sv
// Bench: directed scenario tasks for the watchdog reboot status register.
module wdr_status_top_tb_top;
    localparam int CLK_PER = 10;
    localparam int RST_CYC = 8;
    localparam logic [3:0] DFLT = 4'h5;

    logic        clk = 1'b0;
    logic        rsm_rst_n = 1'b0, rtc_rst_n = 1'b0;
    logic        wd_to = 1'b0, fetched = 1'b1, intrude = 1'b0;
    logic [7:0]  addr = 8'h06;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  mult_dflt = DFLT;
    logic        plat_rst;
    logic [3:0]  mult_sel;

    int nvec = 0, nfail = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    wdr_status_top #(.RST_CYC(RST_CYC)) dut_i (
        .clk(clk), .rsm_rst_n(rsm_rst_n), .rtc_rst_n(rtc_rst_n),
        .wd_to_i(wd_to), .cpu_fetched_i(fetched), .intrude_i(intrude),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .mult_default_i(mult_dflt),
        .plat_rst_o(plat_rst), .mult_sel_o(mult_sel));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        addr = a; #1; v = rdata; addr = 8'h06;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
        addr = a; wr = 1'b1; wdata = d;
        step();
        wr = 1'b0; wdata = '0; addr = 8'h06;
    endtask

    task automatic fire_to();
        wd_to = 1'b1; step(); wd_to = 1'b0;
    endtask

    task automatic settle();
        repeat (RST_CYC + 2) step();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rsm_rst_n = 0; rtc_rst_n = 0; step(); step();
        rsm_rst_n = 1; rtc_rst_n = 1; step();
        rd(8'h06, v);
        chk("R1 reset value", v, 16'h0000);
        chk("R1 plat_rst low", plat_rst, 0);
        chk("R1 multiplier default", mult_sel, DFLT);
    endtask

    task automatic t_timeout_held();
        logic [15:0] v;
        fetched = 1; wd_to = 1; step();
        rd(8'h06, v);
        chk("R2 timeout set", v, 16'h0002);
        chk("R4 no boot when fetched", v[2], 0);
        wr_reg(8'h06, 16'h0002);
        rd(8'h06, v);
        chk("R3 write-1 clears timeout", v, 16'h0000);
        step(); step();
        rd(8'h06, v);
        chk("R2 held input sets once", v, 16'h0000);
        wd_to = 0; settle();
    endtask

    task automatic t_ignored_writes();
        logic [15:0] v;
        fetched = 1; fire_to(); settle();
        wr_reg(8'h06, 16'h0000);
        rd(8'h06, v); chk("R3 write 0 no effect", v, 16'h0002);
        wr_reg(8'h04, 16'h0002);
        rd(8'h06, v); chk("R3 other offset no effect", v, 16'h0002);
        rd(8'h04, v); chk("R10 other offset reads 0", v, 16'h0000);
        wr_reg(8'h06, 16'hFFF8);
        rd(8'h06, v); chk("R10 reserved write ignored", v, 16'h0002);
        wr_reg(8'h06, 16'h0002);
    endtask

    task automatic t_pulse_len();
        int hi = 0;
        fetched = 1; wd_to = 1; step(); wd_to = 0;
        chk("R7 pulse starts with status", plat_rst, 1);
        chk("R8 default mult when fetched", mult_sel, DFLT);
        for (int i = 0; i < RST_CYC + 4; i++) begin
            if (plat_rst) hi++;
            step();
        end
        chk("R7 pulse length", hi, RST_CYC);
        wr_reg(8'h06, 16'h0002);
    endtask

    task automatic t_boot_fail();
        logic [15:0] v;
        fetched = 0; fire_to();
        rd(8'h06, v);
        chk("R4 boot and timeout set", v, 16'h0006);
        chk("R8 safe mult in pulse", mult_sel, 4'hF);
        settle();
        chk("R8 safe mult after pulse", mult_sel, 4'hF);
        wr_reg(8'h06, 16'h0002);
        chk("R8 default after timeout cleared", mult_sel, DFLT);
        rd(8'h06, v); chk("R5 boot kept", v, 16'h0004);
        wr_reg(8'h06, 16'h0004);
        rd(8'h06, v); chk("R5 boot cleared", v, 16'h0000);
        fetched = 1;
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        fire_to(); settle();
        wd_to = 1; wr_reg(8'h06, 16'h0002); wd_to = 0;
        rd(8'h06, v); chk("R6 timeout set beats clear", v[1], 1);
        intrude = 1; step(); intrude = 0; step();
        intrude = 1; wr_reg(8'h06, 16'h0001); intrude = 0;
        rd(8'h06, v); chk("R6 intrusion set beats clear", v[0], 1);
        wr_reg(8'h06, 16'h0003); settle();
    endtask

    task automatic t_intrusion();
        logic [15:0] v;
        rsm_rst_n = 0; step();
        intrude = 1; step(); intrude = 0;
        rd(8'h06, v); chk("R9 intrusion set in resume reset", v, 16'h0001);
        step(); rsm_rst_n = 1; step();
        rd(8'h06, v); chk("R9 resume reset keeps intrusion", v, 16'h0001);
        rtc_rst_n = 0; step(); rtc_rst_n = 1;
        rd(8'h06, v); chk("R9 rtc reset clears intrusion", v, 16'h0000);
        intrude = 1; step(); intrude = 0;
        wr_reg(8'h06, 16'h0001);
        rd(8'h06, v); chk("R9 write-1 clears intrusion", v, 16'h0000);
    endtask

    task automatic t_resume_clears();
        logic [15:0] v;
        fetched = 0; fire_to(); fetched = 1;
        rsm_rst_n = 0; step(); rsm_rst_n = 1;
        rd(8'h06, v);
        chk("R3 R5 resume reset clears", v, 16'h0000);
        chk("R7 pulse dropped by reset", plat_rst, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_timeout_held();
        t_ignored_writes();
        t_pulse_len();
        t_boot_fail();
        t_set_wins();
        t_intrusion();
        t_resume_clears();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nvec++; nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule